// File: doc/BRIEF.md
# Linear Streaming Candidate Sorter

This block collects one batch of N candidate metrics. The metrics arrive one per clock cycle on a valid strobe. The block keeps the K smallest of them in a column of registers, in ascending order, with the smallest at the bottom. Each metric has a tag, for example a symbol index, and the tag moves through every exchange together with its metric.

The column is built from two-slot compare-and-select cells and holds no full sorting network. Every incoming value is offered to all slots in the same cycle. A slot keeps its own entry, takes the new value, or takes the entry from the slot beneath it. A batch therefore settles in N cycles, and the logic grows with the number of slots and not with the size of a sorting network. Before each batch a start pulse presets every slot to all ones. One extra key bit marks empty slots, so a real input equal to the largest metric still wins against an empty slot.

A one-cycle done pulse reports that the N-th metric has been absorbed. The result then stays stable until the next start. A parameter chooses the column height. The full variant has N slots, which is N/2 cells. The trimmed variant has only the K (rounded up to even) slots that can reach the output.

Top module: `linear_stream_sorter`

## Requirements
- R1: After reset, and in the cycle after a start pulse, every output metric reads all ones, every output tag reads zero, and done is low.
- R2: Every cycle, output slot i (bits i*MW upward, slot 0 at the least significant end) holds a metric no larger than slot i+1.
- R3: Done is high for exactly one cycle. That cycle is the one after the edge that absorbed the N-th accepted input of the batch. Done is low while fewer than N inputs have been accepted.
- R4: When done is high, the K output slots hold the K smallest metrics of the batch, and that includes inputs equal to the all-ones value.
- R5: Each output tag is the tag that arrived with the metric shown in the same slot.
- R6: Among equal metrics, the one that arrived earlier sits in the lower slot.
- R7: Inputs offered after the N-th accepted input and before the next start change no output.
- R8: A cycle with start high discards any input offered in that same cycle.
- R9: In a cycle with both in_valid and start low, the outputs do not change.
- R10: The full column variant (N slots) and the trimmed variant (K slots rounded up to even) produce identical outputs for the same input stream.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, same effect as start |
| start | input | 1 | Clears the column and the count for a new batch |
| in_valid | input | 1 | Offers in_metric and in_tag this cycle |
| in_metric | input | MW | Unsigned candidate metric |
| in_tag | input | TW | Tag carried with the metric |
| out_metric | output | K*MW | K smallest metrics, slot 0 lowest |
| out_tag | output | K*TW | Tags matching out_metric slots |
| done | output | 1 | One-cycle pulse after the N-th input is absorbed |

## Verification
The bench builds two copies with N=8, K=3, a 6-bit metric and a 4-bit tag. One copy uses the trimmed column, and its odd K leaves one slot that never reaches the output. The other copy uses the full column. Both copies take the same stream and are compared with the same stable reference sort. Because the metric is narrow and the random batches use a small value range, ties, repeated values and all-ones inputs occur often. This exercises the stability rule and the extra empty-slot bit. The small N also lets the bench cover the extra inputs after done and a start raised together with valid within a few cycles.

// File: rtl/lss_pkg.sv
package lss_pkg;
   typedef enum logic [0:0] {
      LSS_COL_FULL = 1'b0,
      LSS_COL_TRIM = 1'b1
   } lss_col_e;

   function automatic int lss_slots(input int n, input int k, input lss_col_e col);
      if (col == LSS_COL_FULL) return n;
      return k + (k % 2);
   endfunction
endpackage

// File: rtl/lss_cell.sv
module lss_cell #(
   parameter int KW = 9,
   parameter int TW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          en,
   input  logic [KW-1:0] x_key,
   input  logic [TW-1:0] x_tag,
   input  logic [KW-1:0] below_key,
   input  logic [TW-1:0] below_tag,
   output logic [KW-1:0] lo_key,
   output logic [TW-1:0] lo_tag,
   output logic [KW-1:0] hi_key,
   output logic [TW-1:0] hi_tag
);
   logic          lo_take, lo_from_x, hi_take, hi_from_x;
   logic [KW-1:0] lo_key_n, hi_key_n;
   logic [TW-1:0] lo_tag_n, hi_tag_n;

   // strict compare: an equal stored entry stays below the newcomer
   always_comb begin
      lo_take   = x_key < lo_key;
      lo_from_x = !(x_key < below_key);
      hi_take   = x_key < hi_key;
      hi_from_x = !lo_take;
      lo_key_n  = lo_key;
      lo_tag_n  = lo_tag;
      hi_key_n  = hi_key;
      hi_tag_n  = hi_tag;
      if (lo_take) begin
         lo_key_n = lo_from_x ? x_key : below_key;
         lo_tag_n = lo_from_x ? x_tag : below_tag;
      end
      if (hi_take) begin
         hi_key_n = hi_from_x ? x_key : lo_key;
         hi_tag_n = hi_from_x ? x_tag : lo_tag;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_key <= '1;
         hi_key <= '1;
         lo_tag <= '0;
         hi_tag <= '0;
      end else if (clr) begin
         lo_key <= '1;
         hi_key <= '1;
         lo_tag <= '0;
         hi_tag <= '0;
      end else if (en) begin
         lo_key <= lo_key_n;
         hi_key <= hi_key_n;
         lo_tag <= lo_tag_n;
         hi_tag <= hi_tag_n;
      end
   end
endmodule

// File: rtl/lss_ctrl.sv
module lss_ctrl #(
   parameter int N = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic in_valid,
   output logic accept,
   output logic done
);
   localparam int CW = $clog2(N + 1);
   localparam logic [CW-1:0] LAST = CW'(N - 1);
   localparam logic [CW-1:0] FULL = CW'(N);

   logic [CW-1:0] cnt;

   assign accept = in_valid && !start && (cnt != FULL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         done <= 1'b0;
      end else if (start) begin
         cnt  <= '0;
         done <= 1'b0;
      end else begin
         done <= accept && (cnt == LAST);
         if (accept) cnt <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/linear_stream_sorter.sv
module linear_stream_sorter
   import lss_pkg::*;
#(
   parameter int       N   = 8,
   parameter int       K   = 3,
   parameter int       MW  = 8,
   parameter int       TW  = 4,
   parameter lss_col_e COL = LSS_COL_TRIM
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            start,
   input  logic            in_valid,
   input  logic [MW-1:0]   in_metric,
   input  logic [TW-1:0]   in_tag,
   output logic [K*MW-1:0] out_metric,
   output logic [K*TW-1:0] out_tag,
   output logic            done
);
   localparam int SLOTS = lss_slots(N, K, COL);
   localparam int CELLS = SLOTS / 2;
   localparam int KW    = MW + 1;

   if (N % 2 != 0) begin : g_bad_n
      $error("linear_stream_sorter: N must be even");
   end
   if (K < 1 || K > N) begin : g_bad_k
      $error("linear_stream_sorter: K must lie in 1..N");
   end
   if (MW < 1 || TW < 1) begin : g_bad_w
      $error("linear_stream_sorter: widths must be positive");
   end

   logic          accept;
   logic [KW-1:0] x_key;
   logic [KW-1:0] key [SLOTS];
   logic [TW-1:0] tag [SLOTS];

   // extra MSB set means empty slot; real inputs enter with it clear
   assign x_key = {1'b0, in_metric};

   lss_ctrl #(.N(N)) ctrl_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (start),
      .in_valid(in_valid),
      .accept  (accept),
      .done    (done)
   );

   for (genvar c = 0; c < CELLS; c++) begin : g_cell
      logic [KW-1:0] bk;
      logic [TW-1:0] bt;
      if (c == 0) begin : g_floor
         assign bk = '0;
         assign bt = '0;
      end else begin : g_stack
         assign bk = key[2*c-1];
         assign bt = tag[2*c-1];
      end
      lss_cell #(.KW(KW), .TW(TW)) cell_i (
         .clk      (clk),
         .rst_n    (rst_n),
         .clr      (start),
         .en       (accept),
         .x_key    (x_key),
         .x_tag    (in_tag),
         .below_key(bk),
         .below_tag(bt),
         .lo_key   (key[2*c]),
         .lo_tag   (tag[2*c]),
         .hi_key   (key[2*c+1]),
         .hi_tag   (tag[2*c+1])
      );
   end

   for (genvar i = 0; i < K; i++) begin : g_out
      assign out_metric[i*MW +: MW] = key[i][MW-1:0] | {MW{key[i][MW]}};
      assign out_tag[i*TW +: TW]    = tag[i];
   end
endmodule

// File: rtl/lss_chk.sv
module lss_chk #(
   parameter int N  = 8,
   parameter int K  = 3,
   parameter int MW = 8,
   parameter int TW = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            start,
   input logic            in_valid,
   input logic [K*MW-1:0] out_metric,
   input logic [K*TW-1:0] out_tag,
   input logic            done
);
   function automatic logic is_ascending(input logic [K*MW-1:0] m);
      for (int i = 0; i + 1 < K; i++)
         if (m[i*MW +: MW] > m[(i+1)*MW +: MW]) return 1'b0;
      return 1'b1;
   endfunction

   // R1
   clear_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start |=> (out_metric == '1) && (out_tag == '0) && !done);

   // R2
   ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
      is_ascending(out_metric));

   // R3
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R3
   done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $past(in_valid) && !$past(start));

   // R7
   hold_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !start |=> $stable(out_metric) && $stable(out_tag));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid && !start |=> $stable(out_metric) && $stable(out_tag));
endmodule

bind linear_stream_sorter lss_chk #(.N(N), .K(K), .MW(MW), .TW(TW)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .in_valid  (in_valid),
   .out_metric(out_metric),
   .out_tag   (out_tag),
   .done      (done)
);

// File: tb/linear_stream_sorter_tb_top.sv
module linear_stream_sorter_tb_top;
   import lss_pkg::*;
   localparam int N = 8, K = 3, MW = 6, TW = 4;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
   logic [MW-1:0] in_metric = '0;
   logic [TW-1:0] in_tag = '0;
   logic [K*MW-1:0] om_t, om_f;
   logic [K*TW-1:0] ot_t, ot_f;
   logic dn_t, dn_f;
   int n_run = 0, n_fail = 0;
   logic [MW-1:0] bm [N];
   logic [TW-1:0] bt [N];
   logic [MW-1:0] em [N];
   logic [TW-1:0] et [N];

   always #2 clk = ~clk;

   linear_stream_sorter #(.N(N), .K(K), .MW(MW), .TW(TW), .COL(LSS_COL_TRIM)) dut_i (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_metric(in_metric), .in_tag(in_tag),
      .out_metric(om_t), .out_tag(ot_t), .done(dn_t));

   linear_stream_sorter #(.N(N), .K(K), .MW(MW), .TW(TW), .COL(LSS_COL_FULL)) dut_f (
      .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
      .in_metric(in_metric), .in_tag(in_tag),
      .out_metric(om_f), .out_tag(ot_f), .done(dn_f));

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   // stable insertion sort: equal metrics keep arrival order
   task automatic ref_sort();
      for (int i = 0; i < N; i++) begin em[i] = bm[i]; et[i] = bt[i]; end
      for (int i = 1; i < N; i++) begin
         for (int j = i; j > 0 && em[j-1] > em[j]; j--) begin
            logic [MW-1:0] tm; logic [TW-1:0] tt;
            tm = em[j]; em[j] = em[j-1]; em[j-1] = tm;
            tt = et[j]; et[j] = et[j-1]; et[j-1] = tt;
         end
      end
   endtask

   task automatic check_result(input string req);
      for (int i = 0; i < K; i++) begin
         chk({req, " R4 metric trim"}, int'(om_t[i*MW +: MW]), int'(em[i]));
         chk({req, " R5 tag trim"}, int'(ot_t[i*TW +: TW]), int'(et[i]));
         chk({req, " R10 metric full"}, int'(om_f[i*MW +: MW]), int'(em[i]));
         chk({req, " R10 tag full"}, int'(ot_f[i*TW +: TW]), int'(et[i]));
      end
   endtask

   task automatic check_clear(input string req);
      chk({req, " metric"}, int'(om_t == '1), 1);
      chk({req, " tag"}, int'(ot_t == '0), 1);
      chk({req, " done"}, int'(dn_t), 0);
   endtask

   task automatic pulse_start();
      @(negedge clk) start = 1'b1;
      @(negedge clk) start = 1'b0;
   endtask

   task automatic run_batch(input string req);
      pulse_start();
      check_clear("R1 after start");
      for (int i = 0; i < N; i++) begin
         in_valid = 1'b1; in_metric = bm[i]; in_tag = bt[i];
         @(negedge clk);
         if (i < N - 1) chk("R3 early done", int'(dn_t | dn_f), 0);
      end
      in_valid = 1'b0;
      chk("R3 done trim", int'(dn_t), 1);
      chk("R3 done full", int'(dn_f), 1);
      ref_sort();
      check_result(req);
      @(negedge clk);
      chk("R3 single pulse", int'(dn_t | dn_f), 0);
   endtask

   initial begin
      #200000;
      n_fail++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      check_clear("R1 reset");
      rst_n = 1'b1;
      @(negedge clk);
      check_clear("R1 after release");

      for (int i = 0; i < N; i++) begin bm[i] = MW'(i + 3); bt[i] = TW'(i); end
      run_batch("ascending");
      for (int i = 0; i < N; i++) begin bm[i] = MW'(40 - 3*i); bt[i] = TW'(i); end
      run_batch("descending");
      for (int i = 0; i < N; i++) begin bm[i] = 6'd9; bt[i] = TW'(i + 5); end
      run_batch("R6 all equal");
      for (int i = 0; i < N; i++) begin bm[i] = '1; bt[i] = TW'(15 - i); end
      run_batch("R4 all max");
      for (int i = 0; i < N; i++) begin bm[i] = (i % 3 == 0) ? 6'd2 : 6'd7; bt[i] = TW'(i); end
      run_batch("R6 interleaved ties");

      // R7: extra inputs after the batch completes are ignored
      @(negedge clk) begin in_valid = 1'b1; in_metric = 6'd0; in_tag = 4'd14; end
      @(negedge clk) in_valid = 1'b0;
      check_result("R7 after extra input");

      // R8: input together with start is dropped
      @(negedge clk) begin start = 1'b1; in_valid = 1'b1; in_metric = 6'd0; in_tag = 4'd13; end
      @(negedge clk) begin start = 1'b0; in_valid = 1'b0; end
      check_clear("R8 start with valid");
      @(negedge clk);
      check_clear("R9 idle after start");

      for (int b = 0; b < 30; b++) begin
         for (int i = 0; i < N; i++) begin
            bm[i] = (b % 2 == 0) ? MW'($urandom_range(0, 7)) : MW'($urandom_range(0, 63));
            bt[i] = TW'($urandom);
         end
         run_batch("random");
      end

      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule